// File: doc/BRIEF.md
# Serial NOR Erase Range Sequencer

This block turns one erase request, given as a start address and a byte length, into the series of erase commands that a serial NOR flash needs. It sends the commands as byte transfers on a simple byte-transfer port. A chip-select output frames each command. A separate byte engine shifts the bits and reports each completed byte.

When the device supports small (4 KiB-class) erase units, the sequencer splits the range into three parts. Small erases cover the part that lies before the first large-sector boundary. Large-sector erases cover the aligned middle. Small erases cover whatever is left at the end. A request that spans the whole device becomes a single chip-erase command.

Each erase is preceded by two steps. First the sequencer reads the status register repeatedly until the device reports idle. Then it sends a write-enable command. After the last erase it waits for idle once more before reporting completion. The final result is one of four outcomes: success, a length error, a polling timeout, or an interruption by the abort input.

Top module: `nor_erase_seq`

## Requirements
- R1: A request whose length is not a whole multiple of the active erase unit completes with result 2'b01 and drives no chip-select frame. The active unit is the small unit when `cfg_small_en`=1 and the large sector when `cfg_small_en`=0.
- R2: A request whose length equals the device size (2^DEV_LOG2 bytes) produces exactly one erase frame, and that frame is the single byte 0xC7.
- R3: With `cfg_small_en`=1, each step is chosen as follows:
  - It issues 0x20 (small erase) while the current address is not aligned to the large sector.
  - Otherwise it issues 0xD8 (large erase) while at least one large sector of length remains.
  - Otherwise it issues 0x20.
  - After each step the address advances, and the length shrinks, by the size of the unit just erased.
- R4: With `cfg_small_en`=0, every step is one 0xD8 erase, and the address advances by one large sector per step until the length is used up.
- R5: Before every erase frame, the block sends status frames {0x05, 0x00} until the second returned byte has bit 0 (write in progress) clear. It then sends the one-byte frame 0x06 (write enable) as its own frame, and only then the erase frame.
- R6: A small or large erase frame is the opcode followed by the address, most significant byte first. The address is 3 bytes when `cfg_addr4`=0 and 4 bytes when `cfg_addr4`=1.
- R7: After the last erase frame, the block polls status until idle and then completes with result 2'b00. A zero-length request only polls, then completes with result 2'b00 and no erase frame.
- R8: If status still reads busy once polling has lasted TMO_CYCLES cycles, the request completes with result 2'b10 and no further erase frame.
- R9: `abort_req` is sampled after each erase frame while length remains. If it is high, the request completes with result 2'b11 and no further frame. It is never sampled after the last erase.
- R10: `busy` is high from the cycle after a request is accepted through the one-cycle `done` pulse. `req_valid` is ignored while `busy` is high, and no chip-select frame occurs while idle.
- R11: `xfer_start` pulses for one cycle, only while `spi_cs` is high, and at most one byte is outstanding at a time. `spi_cs` drops only after the final `xfer_done` of a frame, and stays low for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request, taken when idle |
| req_addr | input | DEV_LOG2 | Start byte address |
| req_len | input | DEV_LOG2+1 | Length in bytes |
| cfg_small_en | input | 1 | Device supports small-unit erase |
| cfg_addr4 | input | 1 | Use 4 address bytes in erase frames |
| abort_req | input | 1 | Stop the sequence between erases |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 ok, 01 length error, 10 timeout, 11 aborted; valid with done |
| spi_cs | output | 1 | Frame active (chip select asserted) |
| xfer_start | output | 1 | Start one byte transfer |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Byte transfer finished |
| xfer_rx | input | 8 | Byte received during the finished transfer |

## Verification
The checker assumes a well-behaved byte engine. It answers each `xfer_start` with exactly one `xfer_done`, at least one cycle later, and never raises `xfer_done` with nothing in flight. The bench's flash model keeps to this: each byte completes after a fixed short delay. The model also assumes every request stays inside the device (address plus length no larger than the device size). The sweeps only build ranges that end at or before the top of the device. Configuration inputs are held steady for the whole of each request.

// File: rtl/nor_erase_seq.sv
`timescale 1ns/1ps
module nor_erase_seq #(
  parameter int DEV_LOG2   = 24,
  parameter int LARGE_LOG2 = 16,
  parameter int SMALL_LOG2 = 12,
  parameter longint unsigned TMO_CYCLES = 64'd4_000_000_000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [DEV_LOG2-1:0] req_addr,
  input  logic [DEV_LOG2:0]   req_len,
  input  logic                cfg_small_en,
  input  logic                cfg_addr4,
  input  logic                abort_req,
  output logic                busy,
  output logic                done,
  output logic [1:0]          result,
  output logic                spi_cs,
  output logic                xfer_start,
  output logic [7:0]          xfer_tx,
  input  logic                xfer_done,
  input  logic [7:0]          xfer_rx
);
  localparam int AW = DEV_LOG2;
  localparam int LW = DEV_LOG2 + 1;
  localparam int TW = $clog2(TMO_CYCLES + 1);
  localparam logic [LW-1:0] DEV_BYTES   = LW'(1) << AW;
  localparam logic [LW-1:0] LARGE_BYTES = LW'(1) << LARGE_LOG2;
  localparam logic [LW-1:0] SMALL_BYTES = LW'(1) << SMALL_LOG2;
  localparam logic [TW-1:0] TMO = TW'(TMO_CYCLES);

  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_SMALL = 8'h20;
  localparam logic [7:0] OP_LARGE = 8'hD8;
  localparam logic [7:0] OP_CHIP  = 8'hC7;

  localparam logic [1:0] RES_OK  = 2'b00;
  localparam logic [1:0] RES_LEN = 2'b01;
  localparam logic [1:0] RES_TMO = 2'b10;
  localparam logic [1:0] RES_ABT = 2'b11;

  typedef enum logic [3:0] {
    S_IDLE, S_POLL_OP, S_POLL_RD, S_POLL_CHK, S_WREN,
    S_GAP, S_ERS_OP, S_ERS_ADR, S_ADV, S_FIN
  } st_t;

  st_t            st;
  logic           pend, chip, fin_wait, small_en, addr4, wip;
  logic [AW-1:0]  addr;
  logic [LW-1:0]  len;
  logic [1:0]     bidx;
  logic [TW-1:0]  tmr;

  wire unused_rx = ^xfer_rx[7:1];

  wire           large_aligned = (addr[LARGE_LOG2-1:0] == '0);
  wire           use_large = !small_en || (large_aligned && len >= LARGE_BYTES);
  wire [LW-1:0]  step      = use_large ? LARGE_BYTES : SMALL_BYTES;
  wire [LW-1:0]  nlen      = chip ? '0 : len - step;
  wire [31:0]    addr32    = 32'(addr);
  wire           polling   = (st == S_POLL_OP) || (st == S_POLL_RD) || (st == S_POLL_CHK);
  wire           byte_ok   = pend && xfer_done;
  wire           len_bad   = cfg_small_en ? |req_len[SMALL_LOG2-1:0]
                                          : |req_len[LARGE_LOG2-1:0];

  assign spi_cs     = (st == S_POLL_OP) || (st == S_POLL_RD) || (st == S_WREN) ||
                      (st == S_ERS_OP)  || (st == S_ERS_ADR);
  assign xfer_start = spi_cs && !pend;
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_FIN);

  always_comb begin
    case (st)
      S_POLL_OP: xfer_tx = OP_RDSR;
      S_WREN:    xfer_tx = OP_WREN;
      S_ERS_OP:  xfer_tx = chip ? OP_CHIP : (use_large ? OP_LARGE : OP_SMALL);
      S_ERS_ADR: xfer_tx = addr32[{bidx, 3'b000} +: 8];
      default:   xfer_tx = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          pend <= 1'b0;
    else if (xfer_start) pend <= 1'b1;
    else if (xfer_done)  pend <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !polling) tmr <= '0;
    else if (tmr != TMO)    tmr <= tmr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      result   <= RES_OK;
      chip     <= 1'b0;
      fin_wait <= 1'b0;
      small_en <= 1'b0;
      addr4    <= 1'b0;
      wip      <= 1'b0;
      addr     <= '0;
      len      <= '0;
      bidx     <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          addr     <= req_addr;
          len      <= req_len;
          small_en <= cfg_small_en;
          addr4    <= cfg_addr4;
          chip     <= (req_len == DEV_BYTES);
          fin_wait <= (req_len == '0);
          result   <= RES_OK;
          if (len_bad) begin
            result <= RES_LEN;
            st     <= S_FIN;
          end else begin
            st <= S_POLL_OP;
          end
        end
        S_POLL_OP: if (byte_ok) st <= S_POLL_RD;
        S_POLL_RD: if (byte_ok) begin
          wip <= xfer_rx[0];
          st  <= S_POLL_CHK;
        end
        S_POLL_CHK: begin
          if (!wip)            st <= fin_wait ? S_FIN : S_WREN;
          else if (tmr == TMO) begin
            result <= RES_TMO;
            st     <= S_FIN;
          end else             st <= S_POLL_OP;
        end
        S_WREN: if (byte_ok) st <= S_GAP;
        S_GAP:  st <= S_ERS_OP;
        S_ERS_OP: if (byte_ok) begin
          if (chip) st <= S_ADV;
          else begin
            bidx <= addr4 ? 2'd3 : 2'd2;
            st   <= S_ERS_ADR;
          end
        end
        S_ERS_ADR: if (byte_ok) begin
          if (bidx == 2'd0) st <= S_ADV;
          else              bidx <= bidx - 2'd1;
        end
        S_ADV: begin
          addr <= addr + AW'(step);
          len  <= nlen;
          if (nlen == '0) begin
            fin_wait <= 1'b1;
            st       <= S_POLL_OP;
          end else if (abort_req) begin
            result <= RES_ABT;
            st     <= S_FIN;
          end else begin
            st <= S_POLL_OP;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module nor_erase_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic busy,
  input logic done,
  input logic spi_cs,
  input logic xfer_start,
  input logic xfer_done
);
  assert_start_in_frame_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> spi_cs);
  assert_single_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !xfer_start);
  assert_frame_close_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs) |-> $past(xfer_done));
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_cs);
  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  assert_busy_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  assert_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
endmodule

bind nor_erase_seq nor_erase_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .spi_cs(spi_cs), .xfer_start(xfer_start), .xfer_done(xfer_done)
);

// File: tb/nor_erase_seq_tb_top.sv
`timescale 1ns/1ps
module nor_erase_seq_tb_top;
  localparam int DL = 16, LL = 14, SL = 12;
  localparam int DEV = 1 << DL, LRG = 1 << LL, SML = 1 << SL;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          req_valid = 1'b0, cfg_small_en = 1'b0, cfg_addr4 = 1'b0, abort_req = 1'b0;
  logic [DL-1:0] req_addr = '0;
  logic [DL:0]   req_len = '0;
  logic          busy, done, spi_cs, xfer_start;
  logic [1:0]    result;
  logic [7:0]    xfer_tx;
  logic          xfer_done = 1'b0;
  logic [7:0]    xfer_rx = 8'h00;

  nor_erase_seq #(.DEV_LOG2(DL), .LARGE_LOG2(LL), .SMALL_LOG2(SL), .TMO_CYCLES(64'd400)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .cfg_small_en(cfg_small_en), .cfg_addr4(cfg_addr4), .abort_req(abort_req),
    .busy(busy), .done(done), .result(result), .spi_cs(spi_cs), .xfer_start(xfer_start),
    .xfer_tx(xfer_tx), .xfer_done(xfer_done), .xfer_rx(xfer_rx));

  int vec = 0, bad = 0;
  bit finished = 0;

  // flash model
  logic       inflight = 0, cs_q = 0, stuck = 0, idle_seen = 0, wel = 0;
  int         dly = 0, fcnt = 0, busy_left = 0, polls = 0, ord_err = 0, proto_err = 0, n_rec = 0;
  logic [7:0] cur_tx = 0;
  logic [7:0] fb [0:7];
  logic [7:0] rec_op [0:31];
  int         rec_addr [0:31];
  int         rec_nab [0:31];

  task automatic frame_end();
    int a;
    case (fb[0])
      8'h05: begin
        polls++;
        if (fcnt != 2) ord_err++;
        if (busy_left == 0 && !stuck) idle_seen = 1;
        else if (busy_left > 0) busy_left--;
      end
      8'h06: begin
        if (fcnt != 1 || !idle_seen) ord_err++;
        wel = 1;
      end
      8'h20, 8'hD8, 8'hC7: begin
        if (!wel) ord_err++;
        wel = 0;
        idle_seen = 0;
        a = 0;
        for (int k = 1; k < fcnt && k < 8; k++) a = (a << 8) | int'(fb[k]);
        if (n_rec < 32) begin
          rec_op[n_rec]   = fb[0];
          rec_addr[n_rec] = a;
          rec_nab[n_rec]  = fcnt - 1;
        end
        n_rec++;
        busy_left = 2;
      end
      default: ord_err++;
    endcase
    fcnt = 0;
  endtask

  always @(posedge clk) begin
    xfer_done <= 1'b0;
    if (xfer_start) begin
      if (inflight || !spi_cs) proto_err++;
      inflight = 1;
      dly = 1;
      cur_tx = xfer_tx;
    end else if (inflight) begin
      if (dly == 0) begin
        inflight = 0;
        xfer_done <= 1'b1;
        xfer_rx <= (fcnt == 1 && fb[0] == 8'h05) ? {7'b0, (busy_left > 0 || stuck)} : 8'h00;
        if (fcnt < 8) fb[fcnt] = cur_tx;
        fcnt++;
      end else dly--;
    end
    if (cs_q && !spi_cs) frame_end();
    cs_q = spi_cs;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic run_case(input int a, input int l, input bit sm, input bit a4,
                          input bit ab, input bit stk, input bit poke);
    logic [7:0] eo [0:31];
    int ea [0:31];
    int en = 0, er = 0, ca = a, cl = l, cyc = 0;
    int unit = sm ? SML : LRG;
    if (l % unit != 0) er = 1;
    else if (l == DEV) begin eo[0] = 8'hC7; ea[0] = 0; en = 1; end
    else begin
      while (cl > 0) begin
        ea[en] = ca;
        if (sm && ((ca % LRG) != 0 || cl < LRG)) begin eo[en] = 8'h20; ca += SML; cl -= SML; end
        else begin eo[en] = 8'hD8; ca += LRG; cl -= LRG; end
        en++;
        if (ab && cl > 0) begin er = 3; break; end
      end
    end
    if (stk && er != 1) begin er = 2; en = 0; end

    @(negedge clk);
    n_rec = 0; ord_err = 0; idle_seen = 0; wel = 0; polls = 0; stuck = stk;
    req_addr = DL'(a); req_len = (DL+1)'(l); cfg_small_en = sm; cfg_addr4 = a4;
    abort_req = ab; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R10 busy after accept", busy, 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      req_addr = '0; req_len = (DL+1)'(LRG); cfg_small_en = ~sm; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0; cfg_small_en = sm;
    end
    while (!done && cyc < 20000) begin @(negedge clk); cyc++; end
    chk(done == 1'b1, "R10 done reached", done, 1);
    chk(result == 2'(er), $sformatf("R1/R8/R9 result a=%0d l=%0d", a, l), result, er);
    @(negedge clk);
    chk(busy == 1'b0, "R10 busy released", busy, 0);
    chk(n_rec == en, $sformatf("R3/R4 erase count a=%0d l=%0d sm=%0d", a, l, sm), n_rec, en);
    for (int i = 0; i < en && i < n_rec && i < 32; i++) begin
      if (eo[i] == 8'hC7) begin
        chk(rec_op[i] == 8'hC7, "R2 chip erase opcode", rec_op[i], 8'hC7);
        chk(rec_nab[i] == 0, "R2 chip erase single byte", rec_nab[i], 0);
      end else begin
        chk(rec_op[i] == eo[i], $sformatf("R3/R4 opcode step %0d", i), rec_op[i], eo[i]);
        chk(rec_addr[i] == ea[i], $sformatf("R6 address step %0d", i), rec_addr[i], ea[i]);
        chk(rec_nab[i] == (a4 ? 4 : 3), "R6 address byte count", rec_nab[i], a4 ? 4 : 3);
      end
    end
    chk(ord_err == 0, "R5 poll/write-enable/erase order", ord_err, 0);
    if (er == 0) chk(idle_seen == 1'b1, "R7 final idle poll before done", idle_seen, 1);
    if (er == 1) chk(polls == 0, "R1 no frame on length error", polls, 0);
    repeat (6) @(negedge clk);
    chk(spi_cs == 1'b0 && busy == 1'b0, "R10 request while busy ignored", spi_cs, 0);
    abort_req = 1'b0;
    stuck = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0, "R10 reset idle", busy, 0);
    chk(spi_cs == 0 && xfer_start == 0, "R11 reset port quiet", spi_cs, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int s = 0; s < 16; s++)
      for (int n = 1; n <= 16 - s; n++)
        run_case(s * SML, n * SML, 1'b1, 1'b0, 1'b0, 1'b0, (s == 1 && n == 10));
    for (int b = 0; b < 4; b++)
      for (int n = 1; n <= 4 - b; n++)
        run_case(b * LRG, n * LRG, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case(3 * SML, 9 * SML, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case(LRG, 2 * LRG, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    run_case(0, SML + 512, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case(0, SML, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case(2 * SML, 0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    run_case(0, 2 * SML, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_case(SML, 8 * SML, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_case(0, DEV, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_case(LRG, LRG, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk(proto_err == 0, "R11 byte port protocol", proto_err, 0);
    finish_run();
  end
endmodule